// File: doc/BRIEF.md
# SD Tuning Sequencer

This block runs the sampling-clock tuning procedure of an SD/eMMC host controller by itself, with no processor in the loop. A single start pulse carries the tuning opcode and a flag telling whether the card bus is 8 bits wide. The sequencer then works through the controller's registers on a simple request/acknowledge register bus. It also drives a command-issue handshake. At the end it reports pass or fail.

The procedure has four phases. First the sequencer arms tuning in Host Control 2 (16-bit register at byte offset 0x3E; bit 6 starts tuning, bit 7 reports that the tuned sampling clock is selected). It then narrows the interrupt status-enable register (0x34) and signal-enable register (0x38) to the buffer-read-ready source only. Next it loops: it programs a single-block read, issues the tuning command and re-reads Host Control 2. It leaves the loop once bit 6 drops or once the retry budget is used up. Finally it restores the interrupt enables.

Register writes are 16- or 32-bit wide. Each one is placed on its byte lanes of the bus word with byte enables, so no read-modify-write of a neighbouring half-word ever happens.

Top module: `sdtune_seq`

## Requirements
- R1: After reset, `busy`, `done`, `fail`, `reg_req` and `cmd_req` are all 0.
- R2: On a start pulse while idle, the sequencer first reads Host Control 2. This is a read of word 0x3C with `reg_be`=4'b1100, and the register is taken from `reg_rdata[31:16]`. It then writes that value back with bit 6 set and all other bits unchanged.
- R3: After arming, it writes 0x0000_0020 with `reg_be`=4'b1111 to 0x34 and then to 0x38.
- R4: Each iteration writes block count 0x0001 at offset 0x06, then transfer mode 0x0010 (read direction) at 0x0C. It then raises `cmd_req` with `cmd_index` equal to the start opcode and `cmd_resp`=2'b10. A 16-bit write at offset o uses word o&~3, `reg_be`=2'b11<<(o%4) and data shifted by 8*(o%4). A register request and the command request are never raised together.
- R5: Each iteration begins with a 16-bit write at offset 0x04 of (7<<12)|size. The size is 128 only when the opcode is 21 and the 8-bit flag is set; otherwise it is 64.
- R6: After each completed command, Host Control 2 is read again. If bit 6 is still set and fewer than 40 commands have been issued, another iteration follows.
- R7: If bit 6 is still set after the 40th command, the run fails. No more than 40 commands are ever issued in one run.
- R8: If bit 6 reads clear, the run passes when bit 7 is set and fails when bit 7 is clear.
- R9: On failure, Host Control 2 is written with the last value read, with bits 7 and 6 cleared, before the enables are restored.
- R10: Every run ends by writing 0x007F_003B to 0x34 and then 0 to 0x38. A one-cycle `done` pulse follows, with `fail` valid. `fail` is held until the next accepted start.
- R11: A register request keeps its address, data and enables until `reg_ack`, and `cmd_req` stays high until `cmd_done`. A start pulse while `busy` (including the `done` cycle) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Start pulse, taken only when idle |
| opcode | input | 6 | Tuning command index |
| wide_bus | input | 1 | Card bus is 8 bits wide |
| busy | output | 1 | Run in progress, high through the done cycle |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Result of the last run, 1 = failed |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_addr | output | ADDR_W | Bus-word aligned byte address |
| reg_be | output | BUS_W/8 | Byte enables |
| reg_wdata | output | BUS_W | Write data on its byte lanes |
| reg_rdata | input | BUS_W | Read data, valid with reg_ack |
| reg_ack | input | 1 | Access completes this cycle |
| cmd_req | output | 1 | Command issue request |
| cmd_index | output | 6 | Command index |
| cmd_resp | output | 2 | Response type code |
| cmd_done | input | 1 | Command completed this cycle |

## Verification
Two situations can land in one cycle. In the first, the 40th command is the one after which bit 6 reads clear, so the retry budget runs out at the same poll where tuning ends. The bench provokes this by clearing the bit on exactly the 40th command and expects a pass with no 41st command. In the second, a new start pulse arrives in the very cycle `done` is high. The bench drives start at that point and then expects `busy` and `reg_req` to stay low for several cycles. Every bus and command transfer is compared against an expected queue built from the requirements, while the slaves answer after varying delays.

// File: rtl/sdtune_pkg.sv
package sdtune_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_HC2_RD,
      ST_HC2_SET,
      ST_IEN,
      ST_SEN,
      ST_BSZ,
      ST_BCNT,
      ST_TMODE,
      ST_CMD,
      ST_POLL,
      ST_JUDGE,
      ST_CLR,
      ST_REST_IEN,
      ST_REST_SEN,
      ST_DONE
   } seq_state_t;

   // controller register byte offsets
   localparam logic [7:0] OFF_BLKSZ  = 8'h04;
   localparam logic [7:0] OFF_BLKCNT = 8'h06;
   localparam logic [7:0] OFF_XFER   = 8'h0C;
   localparam logic [7:0] OFF_IRQ_EN = 8'h34;
   localparam logic [7:0] OFF_SIG_EN = 8'h38;
   localparam logic [7:0] OFF_HC2    = 8'h3E;

   localparam int HC2_EXEC_BIT  = 6;
   localparam int HC2_TUNED_BIT = 7;
   localparam logic [15:0] HC2_EXEC  = 16'(1 << HC2_EXEC_BIT);
   localparam logic [15:0] HC2_TUNED = 16'(1 << HC2_TUNED_BIT);

   localparam logic [5:0]  OP_TUNE_HS200 = 6'd21;
   localparam logic [15:0] XFER_READ     = 16'h0010;
   localparam logic [15:0] ONE_BLOCK     = 16'h0001;
   localparam logic [1:0]  RESP_R1       = 2'b10;

   typedef struct packed {
      logic [7:0]  off;
      logic        wide32;
      logic        we;
      logic [31:0] data;
   } bus_op_t;

endpackage

// File: rtl/sdtune_blksel.sv
module sdtune_blksel
   import sdtune_pkg::*;
#(
   parameter int BOUNDARY_ARG = 7,
   parameter int SMALL_BLK    = 64,
   parameter int LARGE_BLK    = 128,
   parameter bit HAS_LARGE    = 1'b1
) (
   input  logic [5:0]  opcode,
   input  logic        wide,
   output logic [15:0] blksz
);
   localparam logic [2:0]  BND   = 3'(BOUNDARY_ARG);
   localparam logic [11:0] SMALL = 12'(SMALL_BLK);
   localparam logic [11:0] LARGE = 12'(LARGE_BLK);

   initial begin
      assert (SMALL_BLK > 0 && SMALL_BLK < 4096) else $error("SMALL_BLK out of range");
      assert (LARGE_BLK > 0 && LARGE_BLK < 4096) else $error("LARGE_BLK out of range");
      assert (BOUNDARY_ARG >= 0 && BOUNDARY_ARG < 8) else $error("BOUNDARY_ARG out of range");
   end

   logic use_large;

   generate
      if (HAS_LARGE) begin : g_two_sizes
         assign use_large = (opcode == OP_TUNE_HS200) && wide;
      end else begin : g_one_size
         assign use_large = 1'b0;
      end
   endgenerate

   assign blksz = {1'b0, BND, use_large ? LARGE : SMALL};
endmodule

// File: rtl/sdtune_retry.sv
module sdtune_retry #(
   parameter int MAX_CMDS = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic at_limit
);
   localparam int CNT_W = $clog2(MAX_CMDS + 1);

   initial begin
      assert (MAX_CMDS >= 1) else $error("MAX_CMDS must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else if (inc) cnt_q <= cnt_q + 1'b1;
   end

   assign at_limit = (cnt_q == CNT_W'(MAX_CMDS));

   AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      inc |-> !at_limit); // R7
endmodule

// File: rtl/sdtune_lane.sv
module sdtune_lane
   import sdtune_pkg::*;
#(
   parameter int BUS_W  = 32,
   parameter int ADDR_W = 8
) (
   input  bus_op_t             op,
   output logic [ADDR_W-1:0]   addr,
   output logic [BUS_W/8-1:0]  be,
   output logic [BUS_W-1:0]    wdata,
   input  logic [BUS_W-1:0]    rdata,
   output logic [15:0]         rd16
);
   localparam int BYTES = BUS_W / 8;
   localparam int LANES = BUS_W / 16;
   localparam int SH_W  = $clog2(BYTES);

   initial begin
      assert (BUS_W == 32 || BUS_W == 64) else $error("BUS_W must be 32 or 64");
      assert (ADDR_W >= 8) else $error("ADDR_W must be at least 8");
   end

   logic [SH_W-1:0] byte_sh;
   logic [15:0]     lane_data [LANES];

   assign byte_sh = op.off[SH_W-1:0];
   assign addr    = ADDR_W'(op.off) & ~ADDR_W'(BYTES - 1);
   assign be      = op.wide32 ? (BYTES'(4'hF) << byte_sh) : (BYTES'(2'b11) << byte_sh);
   assign wdata   = BUS_W'(op.data) << {byte_sh, 3'b000};

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         assign lane_data[g] = rdata[16*g +: 16];
      end
   endgenerate

   assign rd16 = lane_data[op.off[SH_W-1:1]];
endmodule

// File: rtl/sdtune_seq.sv
module sdtune_seq
   import sdtune_pkg::*;
#(
   parameter int          BUS_W        = 32,
   parameter int          ADDR_W       = 8,
   parameter int          MAX_CMDS     = 40,
   parameter int          BOUNDARY_ARG = 7,
   parameter int          SMALL_BLK    = 64,
   parameter int          LARGE_BLK    = 128,
   parameter bit          HAS_LARGE    = 1'b1,
   parameter logic [31:0] IRQ_TUNE     = 32'h0000_0020,
   parameter logic [31:0] IRQ_RUN      = 32'h007F_003B
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [5:0]          opcode,
   input  logic                wide_bus,
   output logic                busy,
   output logic                done,
   output logic                fail,
   output logic                reg_req,
   output logic                reg_we,
   output logic [ADDR_W-1:0]   reg_addr,
   output logic [BUS_W/8-1:0]  reg_be,
   output logic [BUS_W-1:0]    reg_wdata,
   input  logic [BUS_W-1:0]    reg_rdata,
   input  logic                reg_ack,
   output logic                cmd_req,
   output logic [5:0]          cmd_index,
   output logic [1:0]          cmd_resp,
   input  logic                cmd_done
);
   seq_state_t  state_q, state_d;
   logic [15:0] hc2_q;
   logic [5:0]  op_q;
   logic        wide_q;
   logic        fail_q;
   bus_op_t     op;
   logic [15:0] rd16;
   logic [15:0] blksz;
   logic        at_limit;
   logic        accept;
   logic        judge_fail;
   logic        rd_state;

   assign accept     = (state_q == ST_IDLE) && start;
   assign rd_state   = (state_q == ST_HC2_RD) || (state_q == ST_POLL);
   assign judge_fail = hc2_q[HC2_EXEC_BIT] ? at_limit : !hc2_q[HC2_TUNED_BIT];

   sdtune_blksel #(
      .BOUNDARY_ARG (BOUNDARY_ARG),
      .SMALL_BLK    (SMALL_BLK),
      .LARGE_BLK    (LARGE_BLK),
      .HAS_LARGE    (HAS_LARGE)
   ) u_blksel (
      .opcode (op_q),
      .wide   (wide_q),
      .blksz  (blksz)
   );

   sdtune_retry #(
      .MAX_CMDS (MAX_CMDS)
   ) u_retry (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (accept),
      .inc      ((state_q == ST_CMD) && cmd_done),
      .at_limit (at_limit)
   );

   sdtune_lane #(
      .BUS_W  (BUS_W),
      .ADDR_W (ADDR_W)
   ) u_lane (
      .op    (op),
      .addr  (reg_addr),
      .be    (reg_be),
      .wdata (reg_wdata),
      .rdata (reg_rdata),
      .rd16  (rd16)
   );

   // next state
   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:     if (start)    state_d = ST_HC2_RD;
         ST_HC2_RD:   if (reg_ack)  state_d = ST_HC2_SET;
         ST_HC2_SET:  if (reg_ack)  state_d = ST_IEN;
         ST_IEN:      if (reg_ack)  state_d = ST_SEN;
         ST_SEN:      if (reg_ack)  state_d = ST_BSZ;
         ST_BSZ:      if (reg_ack)  state_d = ST_BCNT;
         ST_BCNT:     if (reg_ack)  state_d = ST_TMODE;
         ST_TMODE:    if (reg_ack)  state_d = ST_CMD;
         ST_CMD:      if (cmd_done) state_d = ST_POLL;
         ST_POLL:     if (reg_ack)  state_d = ST_JUDGE;
         ST_JUDGE: begin
            if (judge_fail)                  state_d = ST_CLR;
            else if (hc2_q[HC2_EXEC_BIT])    state_d = ST_BSZ;
            else                             state_d = ST_REST_IEN;
         end
         ST_CLR:      if (reg_ack)  state_d = ST_REST_IEN;
         ST_REST_IEN: if (reg_ack)  state_d = ST_REST_SEN;
         ST_REST_SEN: if (reg_ack)  state_d = ST_DONE;
         ST_DONE:                   state_d = ST_IDLE;
         default:                   state_d = ST_IDLE;
      endcase
   end

   // register access selected by the state
   always_comb begin
      op        = '0;
      op.wide32 = 1'b0;
      reg_req   = 1'b1;
      case (state_q)
         ST_HC2_RD, ST_POLL: op.off = OFF_HC2;
         ST_HC2_SET: begin
            op.off  = OFF_HC2;
            op.we   = 1'b1;
            op.data = {16'h0, hc2_q | HC2_EXEC};
         end
         ST_IEN, ST_SEN, ST_REST_IEN, ST_REST_SEN: begin
            op.off    = ((state_q == ST_IEN) || (state_q == ST_REST_IEN)) ? OFF_IRQ_EN : OFF_SIG_EN;
            op.wide32 = 1'b1;
            op.we     = 1'b1;
            op.data   = (state_q == ST_REST_IEN) ? IRQ_RUN :
                        (state_q == ST_REST_SEN) ? 32'h0 : IRQ_TUNE;
         end
         ST_BSZ: begin
            op.off  = OFF_BLKSZ;
            op.we   = 1'b1;
            op.data = {16'h0, blksz};
         end
         ST_BCNT: begin
            op.off  = OFF_BLKCNT;
            op.we   = 1'b1;
            op.data = {16'h0, ONE_BLOCK};
         end
         ST_TMODE: begin
            op.off  = OFF_XFER;
            op.we   = 1'b1;
            op.data = {16'h0, XFER_READ};
         end
         ST_CLR: begin
            op.off  = OFF_HC2;
            op.we   = 1'b1;
            op.data = {16'h0, hc2_q & ~(HC2_EXEC | HC2_TUNED)};
         end
         default: reg_req = 1'b0;
      endcase
   end

   assign reg_we = op.we;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         hc2_q   <= '0;
         op_q    <= '0;
         wide_q  <= 1'b0;
         fail_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            op_q   <= opcode;
            wide_q <= wide_bus;
            fail_q <= 1'b0;
         end
         if (rd_state && reg_ack) hc2_q <= rd16;
         if ((state_q == ST_JUDGE) && judge_fail) fail_q <= 1'b1;
      end
   end

   assign busy      = (state_q != ST_IDLE);
   assign done      = (state_q == ST_DONE);
   assign fail      = fail_q;
   assign cmd_req   = (state_q == ST_CMD);
   assign cmd_index = op_q;
   assign cmd_resp  = RESP_R1;

   AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_req && !reg_ack |=> reg_req && $stable(reg_addr) && $stable(reg_wdata) && $stable(reg_be) && $stable(reg_we)); // R11

   AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_req && !cmd_done |=> cmd_req && $stable(cmd_index)); // R11

   AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_req && cmd_req)); // R4

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && !busy); // R10

   AST_FAIL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !start |=> $stable(fail)); // R10
endmodule

// File: tb/sdtune_seq_bench.sv
module sdtune_seq_bench;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [5:0]  opcode = '0;
   logic        wide_bus = 1'b0;
   logic        busy, done, fail;
   logic        reg_req, reg_we;
   logic [7:0]  reg_addr;
   logic [3:0]  reg_be;
   logic [31:0] reg_wdata;
   logic [31:0] reg_rdata = '0;
   logic        reg_ack = 1'b0;
   logic        cmd_req;
   logic [5:0]  cmd_index;
   logic [1:0]  cmd_resp;
   logic        cmd_done = 1'b0;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int txn = 0;
   int wait_r = 0;
   int wait_c = 0;

   // register/controller model
   logic [15:0] hc2_mem;
   int          clr_after_m;
   logic        tuned_m;
   int          cmd_cnt;
   logic [49:0] exp_q [$];
   logic        exp_fail;

   // hold-stability tracking
   logic        hold_pend = 1'b0;
   logic [44:0] hold_val;

   always #(CLK_P/2) clk = ~clk;

   sdtune_seq u_sdtune_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .wide_bus(wide_bus),
      .busy(busy), .done(done), .fail(fail),
      .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_be(reg_be),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ack(reg_ack),
      .cmd_req(cmd_req), .cmd_index(cmd_index), .cmd_resp(cmd_resp), .cmd_done(cmd_done)
   );

   function automatic string tag_name(input logic [3:0] t);
      case (t)
         4'd2:    return "R2";
         4'd3:    return "R3";
         4'd4:    return "R4";
         4'd5:    return "R5";
         4'd6:    return "R6";
         4'd9:    return "R9";
         4'd10:   return "R10";
         default: return "R11";
      endcase
   endfunction

   // kind: 0 read, 1 write, 2 command
   function automatic void push(input int tag, input int kind, input logic [3:0] be,
                                input logic [7:0] addr, input logic [31:0] data);
      exp_q.push_back({4'(tag), 2'(kind), be, addr, data});
   endfunction

   function automatic void check(input bit ok, input string req, input string what,
                                 input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endfunction

   // compare one completed transfer with the head of the expected queue
   function automatic void compare(input int kind, input logic [3:0] be, input logic [7:0] addr,
                                   input logic [31:0] data);
      logic [49:0] e;
      bit ok;
      if (exp_q.size() == 0) begin
         check(1'b0, "R4", "unexpected transfer", {kind[1:0], be, addr, data}, 0);
         return;
      end
      e  = exp_q.pop_front();
      ok = (e[45:44] == 2'(kind)) && (e[43:40] == be) && (e[39:32] == addr) &&
           ((kind == 0) || (e[31:0] == data));
      check(ok, tag_name(e[49:46]), "transfer", {kind[1:0], be, addr, data}, e[45:0]);
   endfunction

   // slaves and per-clock comparison
   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         if (reg_req && cmd_req) check(1'b0, "R4", "register and command request together", 1, 0);
         if (reg_req && !busy)   check(1'b0, "R11", "request while idle", 1, 0);
         if (hold_pend && reg_req)
            check({reg_we, reg_be, reg_addr, reg_wdata} == hold_val, "R11", "request changed before ack",
                  {reg_we, reg_be, reg_addr, reg_wdata}, hold_val);

         if (reg_ack) begin
            reg_ack = 1'b0;
            wait_r  = 0;
         end else if (reg_req) begin
            if (wait_r >= txn % 3) begin
               reg_ack = 1'b1;
               compare(reg_we ? 1 : 0, reg_be, reg_addr, reg_wdata);
               reg_rdata = {hc2_mem, 16'h0000};
               if (reg_we && reg_addr == 8'h3C && reg_be == 4'b1100) hc2_mem = reg_wdata[31:16];
               txn++;
            end else wait_r++;
         end
         hold_pend = reg_req && !reg_ack;
         hold_val  = {reg_we, reg_be, reg_addr, reg_wdata};

         if (cmd_done) begin
            cmd_done = 1'b0;
            wait_c   = 0;
         end else if (cmd_req) begin
            if (wait_c >= (txn + 1) % 3) begin
               cmd_done = 1'b1;
               compare(2, 4'h0, 8'h00, {24'h0, cmd_index, cmd_resp});
               cmd_cnt++;
               if (cmd_cnt == clr_after_m) begin
                  hc2_mem[6] = 1'b0;
                  hc2_mem[7] = tuned_m;
               end
               txn++;
            end else wait_c++;
         end
      end
   end

   task automatic run(input logic [5:0] opc, input logic wide, input int clr_after,
                      input logic tuned, input bit poke_busy, input bit poke_done);
      logic [15:0] blk;
      int n;
      int guard;
      blk = ((opc == 6'd21) && wide) ? 16'h7080 : 16'h7040;   // R5
      n   = (clr_after >= 1 && clr_after <= 40) ? clr_after : 40;
      exp_fail = !((n == clr_after) && tuned);
      push(2, 0, 4'hC, 8'h3C, 32'h0);
      push(2, 1, 4'hC, 8'h3C, {16'h0053, 16'h0});
      push(3, 1, 4'hF, 8'h34, 32'h0000_0020);
      push(3, 1, 4'hF, 8'h38, 32'h0000_0020);
      for (int i = 0; i < n; i++) begin
         push(5, 1, 4'h3, 8'h04, {16'h0, blk});
         push(4, 1, 4'hC, 8'h04, {16'h0001, 16'h0});
         push(4, 1, 4'h3, 8'h0C, 32'h0000_0010);
         push(4, 2, 4'h0, 8'h00, {24'h0, opc, 2'b10});
         push(6, 0, 4'hC, 8'h3C, 32'h0);
      end
      if (exp_fail) push(9, 1, 4'hC, 8'h3C, {16'h0013, 16'h0});
      push(10, 1, 4'hF, 8'h34, 32'h007F_003B);
      push(10, 1, 4'hF, 8'h38, 32'h0);

      hc2_mem     = 16'h0013;
      clr_after_m = clr_after;
      tuned_m     = tuned;
      cmd_cnt     = 0;

      @(negedge clk);
      opcode = opc; wide_bus = wide; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R11", "busy after start", busy, 1);
      if (poke_busy) begin
         repeat (3) @(negedge clk);
         opcode = 6'd21; wide_bus = ~wide; start = 1'b1;   // R11 must be ignored
         @(negedge clk);
         start = 1'b0;
      end
      guard = 0;
      while (!done && guard < 20000) begin
         @(negedge clk);
         guard++;
      end
      if (!done) begin
         check(1'b0, "R10", "watchdog, no done", 0, 1);
         return;
      end
      check(fail == exp_fail, (n == 40 && clr_after != 40) ? "R7" : "R8", "fail result", fail, exp_fail);
      check(exp_q.size() == 0, "R10", "transfers left at done", exp_q.size(), 0);
      if (poke_done) begin
         opcode = 6'd19; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      check(!done && !busy, "R10", "done is a single pulse", {done, busy}, 0);
      check(fail == exp_fail, "R10", "fail held after done", fail, exp_fail);
      repeat (4) @(negedge clk);
      check(!busy && !reg_req && !cmd_req, "R11", "start in done cycle ignored",
            {busy, reg_req, cmd_req}, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check({busy, done, fail, reg_req, cmd_req} == 5'b0, "R1", "reset state",
            {busy, done, fail, reg_req, cmd_req}, 0);

      run(6'd19, 1'b0, 3,  1'b1, 1'b0, 1'b1);  // SD opcode, pass after 3 commands
      run(6'd21, 1'b1, 1,  1'b1, 1'b1, 1'b0);  // large block, start while busy
      run(6'd21, 1'b0, 2,  1'b0, 1'b0, 1'b0);  // exec clears without tuned clock, R8
      run(6'd19, 1'b1, 0,  1'b1, 1'b0, 1'b0);  // never clears, R7 and R9
      run(6'd21, 1'b1, 40, 1'b1, 1'b0, 1'b1);  // clears on last allowed command

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_P * 150000);
      errors++;
      $display("FAIL R10 watchdog expired: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule